// File: doc/BRIEF.md
# Full-Search Block-Matching Motion Estimator

This block finds the motion vector of one square luminance block by exhaustive search. For every candidate displacement inside a fixed search range there is one processing element. Each element sums the absolute differences between the current block and the reference block at its displacement. A selection tree then reports the displacement with the smallest sum, together with that sum.

The search window around the block is streamed in column-major order, one sample per clock. Inside the block, a delay line turns that single stream into the reference sample each element needs, so all elements accumulate in parallel. Current-block pixels are presented alongside the window samples that complete each of their comparisons, also column-major. The window is `BLK + 2*HALF - 1` samples on each side. Candidates run from `-HALF` to `HALF-1` in x and y.

At image borders the caller raises edge flags with the block-start strobe. Candidates that would reach outside the image are then dropped from the selection, so the window samples lying outside the image are don't-care and the stream can start at once. A new block may start in the cycle after the last sample of the previous one. The result of the previous block is still delivered intact.

Top module: `sad_motion_est`

## Requirements
- R1: While rst_ni is low and after its release, done_o is 0 and mv_x_o, mv_y_o and sad_o are 0 until the first result.
- R2: The window is W = BLK+2*HALF-1 samples square and is sent column by column, with the row index changing fastest. A sample is taken only on a clock where win_vld_i is 1 and start_i is 0, after a start_i and before the W*W-th sample. Cycles with win_vld_i low, or samples sent with no block open, change nothing.
- R3: With N = 2*HALF, cur_px_i is used on each taken sample at window column c and row r where both c and r are at least N-1. That value is the current-block pixel at column c-(N-1) and row r-(N-1).
- R4: The SAD of a candidate is the exact sum over the BLK*BLK pixels of |cur - ref|, with no wrap. With the default sizes this is at most 256*1023 in a 19-bit result.
- R5: start_i clears every accumulation and the window position. Samples of an unfinished earlier block have no effect on the next result.
- R6: The reported candidate has the smallest SAD among the allowed candidates. Candidate (ix, iy), with ix and iy in 0..N-1, compares the current pixel at (x, y) with window sample (x+ix, y+iy). mv_x_o = ix-HALF and mv_y_o = iy-HALF, in log2(N)-bit two's complement.
- R7: Among equal minimum SADs, the candidate with the lowest index iy*N+ix wins.
- R8: The flags edge_left_i, edge_right_i, edge_top_i and edge_bot_i are sampled with start_i. They exclude, in turn, candidates with mv_x<0, mv_x>0, mv_y<0 and mv_y>0. The zero vector is always allowed.
- R9: done_o is high for exactly one cycle. It rises after the (L+1)-th rising edge that follows the edge taking the final window sample, where L = log2(N*N). The outputs then hold until the next done_o.
- R10: A block start in the cycle right after the final sample of the previous block leaves that previous result intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a block and clears all sums |
| edge_left_i | input | 1 | Block touches the left image border |
| edge_right_i | input | 1 | Block touches the right image border |
| edge_top_i | input | 1 | Block touches the top image border |
| edge_bot_i | input | 1 | Block touches the bottom image border |
| win_vld_i | input | 1 | Window sample valid |
| win_px_i | input | PIX_W | Search-window sample, column-major |
| cur_px_i | input | PIX_W | Current-block pixel matching the sample |
| done_o | output | 1 | One-cycle result strobe |
| mv_x_o | output | log2(2*HALF) | Horizontal vector, two's complement |
| mv_y_o | output | log2(2*HALF) | Vertical vector, two's complement |
| sad_o | output | SAD_W | SAD of the chosen vector |

## Verification
A result is due L+1 clock edges after the edge that takes the last window sample. In the reduced bench (4x4 block, range -2..+1, 16 candidates) that is 5 edges. Pauses in win_vld_i only shift the point from which those edges are counted. When the driver sends the last sample of a block, it stamps the expected item with that due cycle. The monitor, sampling on the falling edge, checks the vector, the SAD and the cycle in which done_o appears, and any strobe with nothing pending is reported.

// File: rtl/sad_me_pkg.sv
package sad_me_pkg;

  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_st_e;

  typedef struct packed {
    logic left;
    logic right;
    logic top;
    logic bot;
  } edge_t;

endpackage

// File: rtl/sad_pe.sv
module sad_pe #(
  parameter int unsigned PIX_W = 10,
  parameter int unsigned SAD_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [PIX_W-1:0] cur_i,
  input  logic [PIX_W-1:0] ref_i,
  output logic [SAD_W-1:0] sad_o
);

  logic [PIX_W-1:0] diff;
  logic [SAD_W-1:0] acc_q;

  assign diff = (cur_i > ref_i) ? (cur_i - ref_i) : (ref_i - cur_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (en_i)  acc_q <= acc_q + SAD_W'(diff);
  end

  assign sad_o = acc_q;

endmodule

// File: rtl/sad_win_line.sv
module sad_win_line #(
  parameter int unsigned PIX_W = 10,
  parameter int unsigned NV    = 16,
  parameter int unsigned WIN   = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             vld_i,
  input  logic [PIX_W-1:0] px_i,
  output logic [PIX_W-1:0] tap_o [NV*NV],
  output logic             acc_en_o,
  output logic             last_o
);
  import sad_me_pkg::*;

  // deepest tap: candidate (0,0) against the newest sample
  localparam int unsigned DEPTH = (NV - 1) * WIN + NV - 1;
  localparam int unsigned CW    = $clog2(WIN);

  scan_st_e         st_q;
  logic [CW-1:0]    row_q, col_q;
  logic             accept, row_end, col_end;
  logic [PIX_W-1:0] sr_q [DEPTH];

  assign accept   = vld_i && !start_i && (st_q == SCAN_RUN);
  assign row_end  = (row_q == CW'(WIN - 1));
  assign col_end  = (col_q == CW'(WIN - 1));
  assign last_o   = accept && row_end && col_end;
  assign acc_en_o = accept && (row_q >= CW'(NV - 1)) && (col_q >= CW'(NV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SCAN_IDLE;
      row_q <= '0;
      col_q <= '0;
    end else if (start_i) begin
      st_q  <= SCAN_RUN;
      row_q <= '0;
      col_q <= '0;
    end else if (accept) begin
      if (row_end) begin
        row_q <= '0;
        col_q <= col_end ? '0 : col_q + 1'b1;
        if (col_end) st_q <= SCAN_IDLE;
      end else begin
        row_q <= row_q + 1'b1;
      end
    end
  end

  // data-only delay line, filled before any tap is consumed
  always_ff @(posedge clk_i) begin
    if (accept) begin
      sr_q[0] <= px_i;
      for (int k = 1; k < DEPTH; k++) sr_q[k] <= sr_q[k-1];
    end
  end

  for (genvar iy = 0; iy < NV; iy++) begin : g_ty
    for (genvar ix = 0; ix < NV; ix++) begin : g_tx
      localparam int unsigned D = (NV - 1 - ix) * WIN + (NV - 1 - iy);
      if (D == 0) begin : g_live
        assign tap_o[iy*NV+ix] = px_i;
      end else begin : g_dly
        assign tap_o[iy*NV+ix] = sr_q[D-1];
      end
    end
  end

endmodule

// File: rtl/sad_min_tree.sv
module sad_min_tree #(
  parameter int unsigned NPE   = 256,
  parameter int unsigned SAD_W = 19,
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [SAD_W-1:0] sad_i [NPE],
  input  logic [NPE-1:0]   ok_i,
  output logic             vld_o,
  output logic             ok_o,
  output logic [SAD_W-1:0] sad_o,
  output logic [IDX_W-1:0] idx_o
);

  localparam int unsigned LVL = $clog2(NPE);
  localparam int unsigned NL  = 1 << LVL;

  logic [SAD_W-1:0] lf_sad [NL];
  logic             lf_ok  [NL];
  logic [IDX_W-1:0] lf_idx [NL];
  logic [SAD_W-1:0] nd_sad [1:NL-1];
  logic             nd_ok  [1:NL-1];
  logic [IDX_W-1:0] nd_idx [1:NL-1];
  logic [LVL-1:0]   vq;

  for (genvar j = 0; j < NL; j++) begin : g_leaf
    assign lf_idx[j] = IDX_W'(j);
    if (j < NPE) begin : g_real
      assign lf_sad[j] = sad_i[j];
      assign lf_ok[j]  = ok_i[j];
    end else begin : g_pad
      assign lf_sad[j] = '0;
      assign lf_ok[j]  = 1'b0;
    end
  end

  // heap order: node i has children 2i (lower indices) and 2i+1
  for (genvar i = 1; i < NL; i++) begin : g_node
    logic [SAD_W-1:0] a_sad, b_sad;
    logic             a_ok, b_ok, pick_b;
    logic [IDX_W-1:0] a_idx, b_idx;
    if (2 * i >= NL) begin : g_from_leaf
      assign a_sad = lf_sad[2*i-NL];
      assign a_ok  = lf_ok[2*i-NL];
      assign a_idx = lf_idx[2*i-NL];
      assign b_sad = lf_sad[2*i+1-NL];
      assign b_ok  = lf_ok[2*i+1-NL];
      assign b_idx = lf_idx[2*i+1-NL];
    end else begin : g_from_node
      assign a_sad = nd_sad[2*i];
      assign a_ok  = nd_ok[2*i];
      assign a_idx = nd_idx[2*i];
      assign b_sad = nd_sad[2*i+1];
      assign b_ok  = nd_ok[2*i+1];
      assign b_idx = nd_idx[2*i+1];
    end
    // upper half wins only on a strictly smaller sum
    assign pick_b = b_ok && (!a_ok || (b_sad < a_sad));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        nd_sad[i] <= '0;
        nd_ok[i]  <= 1'b0;
        nd_idx[i] <= '0;
      end else begin
        nd_sad[i] <= pick_b ? b_sad : a_sad;
        nd_ok[i]  <= a_ok | b_ok;
        nd_idx[i] <= pick_b ? b_idx : a_idx;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vq <= '0;
    else         vq <= {vq[LVL-2:0], vld_i};
  end

  assign vld_o = vq[LVL-1];
  assign ok_o  = nd_ok[1];
  assign sad_o = nd_sad[1];
  assign idx_o = nd_idx[1];

endmodule

// File: rtl/sad_motion_est.sv
module sad_motion_est
  import sad_me_pkg::*;
#(
  parameter int unsigned BLK   = 16,
  parameter int unsigned HALF  = 8,
  parameter int unsigned PIX_W = 10,
  parameter int unsigned SAD_W = 19
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic                           edge_left_i,
  input  logic                           edge_right_i,
  input  logic                           edge_top_i,
  input  logic                           edge_bot_i,
  input  logic                           win_vld_i,
  input  logic [PIX_W-1:0]               win_px_i,
  input  logic [PIX_W-1:0]               cur_px_i,
  output logic                           done_o,
  output logic [$clog2(2*HALF)-1:0]      mv_x_o,
  output logic [$clog2(2*HALF)-1:0]      mv_y_o,
  output logic [SAD_W-1:0]               sad_o
);

  // HALF must be a power of two, at least 1
  localparam int unsigned NV    = 2 * HALF;
  localparam int unsigned NPE   = NV * NV;
  localparam int unsigned WIN   = BLK + NV - 1;
  localparam int unsigned VW    = $clog2(NV);
  localparam int unsigned IDX_W = 2 * VW;
  localparam int unsigned LVL   = $clog2(NPE);

  edge_t            edge_q;
  logic [PIX_W-1:0] tap    [NPE];
  logic [SAD_W-1:0] pe_sad [NPE];
  logic [NPE-1:0]   pe_ok;
  logic             acc_en, scan_last, fin_q;
  logic             tr_vld, tr_ok;
  logic [SAD_W-1:0] tr_sad;
  logic [IDX_W-1:0] tr_idx;
  logic             done_q;
  logic [VW-1:0]    mvx_q, mvy_q;
  logic [SAD_W-1:0] sad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      edge_q <= '0;
    else if (start_i) edge_q <= {edge_left_i, edge_right_i, edge_top_i, edge_bot_i};
  end

  sad_win_line #(
    .PIX_W(PIX_W),
    .NV   (NV),
    .WIN  (WIN)
  ) u_line (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .vld_i   (win_vld_i),
    .px_i    (win_px_i),
    .tap_o   (tap),
    .acc_en_o(acc_en),
    .last_o  (scan_last)
  );

  for (genvar iy = 0; iy < NV; iy++) begin : g_row
    for (genvar ix = 0; ix < NV; ix++) begin : g_col
      localparam int unsigned P     = iy * NV + ix;
      localparam bit          NEG_X = (ix < HALF);
      localparam bit          POS_X = (ix > HALF);
      localparam bit          NEG_Y = (iy < HALF);
      localparam bit          POS_Y = (iy > HALF);

      sad_pe #(
        .PIX_W(PIX_W),
        .SAD_W(SAD_W)
      ) u_pe (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .clr_i (start_i),
        .en_i  (acc_en),
        .cur_i (cur_px_i),
        .ref_i (tap[P]),
        .sad_o (pe_sad[P])
      );

      assign pe_ok[P] = !(edge_q.left  && NEG_X) && !(edge_q.right && POS_X) &&
                        !(edge_q.top   && NEG_Y) && !(edge_q.bot   && POS_Y);
    end
  end

  // sums are final one edge after the last sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fin_q <= 1'b0;
    else         fin_q <= scan_last;
  end

  sad_min_tree #(
    .NPE  (NPE),
    .SAD_W(SAD_W),
    .IDX_W(IDX_W)
  ) u_tree (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (fin_q),
    .sad_i (pe_sad),
    .ok_i  (pe_ok),
    .vld_o (tr_vld),
    .ok_o  (tr_ok),
    .sad_o (tr_sad),
    .idx_o (tr_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      mvx_q  <= '0;
      mvy_q  <= '0;
      sad_q  <= '0;
    end else begin
      done_q <= tr_vld;
      if (tr_vld && tr_ok) begin
        mvx_q <= tr_idx[VW-1:0] - VW'(HALF);
        mvy_q <= tr_idx[IDX_W-1:VW] - VW'(HALF);
        sad_q <= tr_sad;
      end
    end
  end

  assign done_o = done_q;
  assign mv_x_o = mvx_q;
  assign mv_y_o = mvy_q;
  assign sad_o  = sad_q;

endmodule

// File: rtl/sad_me_chk.sv
module sad_me_chk
  import sad_me_pkg::*;
#(
  parameter int unsigned VW      = 4,
  parameter int unsigned SAD_W   = 19,
  parameter int unsigned SAD_MAX = 261888,
  parameter int unsigned LAT     = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             edge_left_i,
  input logic             edge_right_i,
  input logic             edge_top_i,
  input logic             edge_bot_i,
  input logic             last_i,
  input logic             done_o,
  input logic [VW-1:0]    mv_x_o,
  input logic [VW-1:0]    mv_y_o,
  input logic [SAD_W-1:0] sad_o
);

  edge_t       blk_q, pend_q;
  int unsigned cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q  <= '0;
      pend_q <= '0;
      cnt_q  <= 0;
    end else begin
      if (start_i) blk_q <= {edge_left_i, edge_right_i, edge_top_i, edge_bot_i};
      if (last_i) pend_q <= blk_q;
      if (last_i)                       cnt_q <= 1;
      else if (cnt_q != 0 && cnt_q < LAT) cnt_q <= cnt_q + 1;
      else                              cnt_q <= 0;
    end
  end

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      rst_quiet_chk: assert (!done_o && sad_o == '0 && mv_x_o == '0 && mv_y_o == '0);
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_due_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAT) |=> done_o);

  // R9
  done_only_due_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(cnt_q) == LAT));

  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable({mv_x_o, mv_y_o, sad_o}));

  // R4
  sad_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (sad_o <= SAD_W'(SAD_MAX)));

  // R8
  edge_left_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pend_q.left) |-> !mv_x_o[VW-1]);

  // R8
  edge_right_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pend_q.right) |-> (mv_x_o[VW-1] || mv_x_o == '0));

  // R8
  edge_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pend_q.top) |-> !mv_y_o[VW-1]);

  // R8
  edge_bot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pend_q.bot) |-> (mv_y_o[VW-1] || mv_y_o == '0));

endmodule

bind sad_motion_est sad_me_chk #(
  .VW     (VW),
  .SAD_W  (SAD_W),
  .SAD_MAX(BLK * BLK * ((1 << PIX_W) - 1)),
  .LAT    (LVL + 1)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .edge_left_i (edge_left_i),
  .edge_right_i(edge_right_i),
  .edge_top_i  (edge_top_i),
  .edge_bot_i  (edge_bot_i),
  .last_i      (scan_last),
  .done_o      (done_o),
  .mv_x_o      (mv_x_o),
  .mv_y_o      (mv_y_o),
  .sad_o       (sad_o)
);

// File: tb/tb_sad_motion_est.sv
module tb_sad_motion_est;

  localparam int CLK_PERIOD = 10;
  localparam int BLK   = 4;
  localparam int HALF  = 2;
  localparam int PIX_W = 10;
  localparam int SAD_W = 19;
  localparam int NV    = 2 * HALF;
  localparam int WIN   = BLK + NV - 1;
  localparam int VW    = $clog2(NV);
  localparam int LAT   = $clog2(NV * NV) + 1;
  localparam int IMG   = 12;
  localparam int PMAX  = (1 << PIX_W) - 1;

  logic clk, rst_ni, start, e_l, e_r, e_t, e_b, win_vld;
  logic [PIX_W-1:0] win_px, cur_px;
  logic done;
  logic [VW-1:0] mv_x, mv_y;
  logic [SAD_W-1:0] sad;

  typedef struct {
    int     vx;
    int     vy;
    int     sad;
    longint due;
    string  tag;
  } exp_t;

  exp_t   q[$];
  int     frame [IMG][IMG];
  int     curf  [IMG][IMG];
  int     junk_val;
  int     n_chk, n_fail;
  longint cyc;
  bit     ended;

  sad_motion_est #(
    .BLK(BLK), .HALF(HALF), .PIX_W(PIX_W), .SAD_W(SAD_W)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .edge_left_i(e_l), .edge_right_i(e_r), .edge_top_i(e_t), .edge_bot_i(e_b),
    .win_vld_i(win_vld), .win_px_i(win_px), .cur_px_i(cur_px),
    .done_o(done), .mv_x_o(mv_x), .mv_y_o(mv_y), .sad_o(sad)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // behavioural full search over allowed candidates, first strict minimum wins
  task automatic ref_search(int bx, int by, output int bvx, output int bvy, output int bsad);
    bit l, r, t, b;
    l = (bx == 0); r = (bx + BLK == IMG); t = (by == 0); b = (by + BLK == IMG);
    bsad = -1; bvx = 0; bvy = 0;
    for (int iy = 0; iy < NV; iy++) begin
      for (int ix = 0; ix < NV; ix++) begin
        int vx, vy, s;
        vx = ix - HALF; vy = iy - HALF;
        if ((l && vx < 0) || (r && vx > 0) || (t && vy < 0) || (b && vy > 0)) continue;
        s = 0;
        for (int y = 0; y < BLK; y++)
          for (int x = 0; x < BLK; x++) begin
            int d;
            d = curf[by+y][bx+x] - frame[by+y+vy][bx+x+vx];
            s += (d < 0) ? -d : d;
          end
        if (bsad < 0 || s < bsad) begin
          bsad = s; bvx = vx; bvy = vy;
        end
      end
    end
  endtask

  task automatic fill_random();
    for (int y = 0; y < IMG; y++)
      for (int x = 0; x < IMG; x++) begin
        frame[y][x] = $urandom_range(PMAX);
        curf[y][x]  = $urandom_range(PMAX);
      end
    junk_val = -1;
  endtask

  task automatic fill_flat(int fv, int cv, int jv);
    for (int y = 0; y < IMG; y++)
      for (int x = 0; x < IMG; x++) begin
        frame[y][x] = fv;
        curf[y][x]  = cv;
      end
    junk_val = jv;
  endtask

  // driver: n_stop >= 0 aborts after that many samples and expects nothing
  task automatic run_block(int bx, int by, bit gaps, string tag, int n_stop = -1);
    exp_t e;
    int bvx, bvy, bsad;
    @(negedge clk);
    start = 1'b1; win_vld = 1'b0;
    e_l = (bx == 0); e_r = (bx + BLK == IMG); e_t = (by == 0); e_b = (by + BLK == IMG);
    @(negedge clk);
    start = 1'b0;
    for (int s = 0; s < WIN * WIN; s++) begin
      int c, r, ix, iy;
      if (n_stop >= 0 && s == n_stop) break;
      if (gaps) begin
        while ($urandom_range(3) == 0) begin
          win_vld = 1'b0;
          win_px  = PIX_W'($urandom_range(PMAX));
          @(negedge clk);
        end
      end
      c = s / WIN; r = s % WIN;
      ix = bx - HALF + c; iy = by - HALF + r;
      win_vld = 1'b1;
      if (ix >= 0 && ix < IMG && iy >= 0 && iy < IMG) win_px = PIX_W'(frame[iy][ix]);
      else win_px = PIX_W'((junk_val < 0) ? $urandom_range(PMAX) : junk_val);
      if (c >= NV - 1 && r >= NV - 1) cur_px = PIX_W'(curf[by+r-NV+1][bx+c-NV+1]);
      else cur_px = PIX_W'($urandom_range(PMAX));
      if (s == WIN * WIN - 1 && n_stop < 0) begin
        ref_search(bx, by, bvx, bvy, bsad);
        e.vx = bvx; e.vy = bvy; e.sad = bsad; e.due = cyc + 1 + LAT; e.tag = tag;
        q.push_back(e);
      end
      @(negedge clk);
    end
    win_vld = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_ni && done) begin
      if (q.size() == 0) begin
        check(1'b0, "R9", "done with nothing pending", 1, 0);
      end else begin
        e = q.pop_front();
        check($signed(mv_x) == e.vx, e.tag, "mv_x", $signed(mv_x), e.vx);
        check($signed(mv_y) == e.vy, e.tag, "mv_y", $signed(mv_y), e.vy);
        check(int'(sad) == e.sad, e.tag, "sad", sad, e.sad);
        check(cyc == e.due, "R9", "result cycle", cyc, e.due);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; ended = 0; junk_val = -1;
    start = 0; e_l = 0; e_r = 0; e_t = 0; e_b = 0;
    win_vld = 0; win_px = '0; cur_px = '0;
    rst_ni = 1'b1;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1", "done in reset", done, 0);
    check(sad == '0, "R1", "sad in reset", sad, 0);
    check(mv_x == '0 && mv_y == '0, "R1", "vector in reset", {mv_x, mv_y}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1", "done after release", done, 0);

    // R2: samples with no open block are ignored
    for (int i = 0; i < 3 * WIN * WIN; i++) begin
      win_vld = 1'b1; win_px = PIX_W'($urandom_range(PMAX));
      @(negedge clk);
    end
    win_vld = 1'b0;
    repeat (LAT + 3) @(negedge clk);
    check(done == 1'b0 && sad == '0, "R2", "idle samples produced output", done, 0);

    // R6: random frames at every block position
    for (int p = 0; p < 9; p++) begin
      fill_random();
      run_block((p % 3) * BLK, (p / 3) * BLK, 1'b0, "R6");
    end

    // R10: back-to-back blocks, start right after the last sample
    for (int p = 0; p < 3; p++) begin
      fill_random();
      run_block(BLK, BLK, 1'b0, "R10");
    end

    // R3: planted exact match at vector (+1,-1)
    fill_random();
    for (int y = 0; y < BLK; y++)
      for (int x = 0; x < BLK; x++) curf[BLK+y][BLK+x] = frame[BLK+y-1][BLK+x+1];
    run_block(BLK, BLK, 1'b0, "R3");

    // R7: flat images, every candidate ties
    fill_flat(500, 500, 500);
    run_block(BLK, BLK, 1'b0, "R7");
    run_block(0, 0, 1'b0, "R7");
    run_block(2 * BLK, 2 * BLK, 1'b0, "R7");

    // R8: outside-image samples would win if not excluded
    fill_flat(PMAX, 0, 0);
    run_block(0, 0, 1'b0, "R8");
    run_block(2 * BLK, 0, 1'b0, "R8");
    run_block(0, 2 * BLK, 1'b0, "R8");
    run_block(2 * BLK, 2 * BLK, 1'b0, "R8");
    run_block(BLK, 0, 1'b0, "R8");

    // R4: largest sums in the interior
    fill_flat(PMAX, 0, PMAX);
    run_block(BLK, BLK, 1'b0, "R4");

    // R2: random pauses in the window stream
    for (int p = 0; p < 4; p++) begin
      fill_random();
      run_block((p % 3) * BLK, (p % 2) * BLK, 1'b1, "R2");
    end

    // R5: aborted blocks leave no trace
    fill_flat(PMAX, 0, PMAX);
    run_block(BLK, BLK, 1'b0, "R5", 20);
    fill_random();
    run_block(BLK, BLK, 1'b0, "R5");
    fill_flat(0, PMAX, 0);
    run_block(0, BLK, 1'b0, "R5", WIN * WIN - 1);
    fill_random();
    run_block(0, BLK, 1'b0, "R5");

    repeat (LAT + 6) @(negedge clk);
    check(q.size() == 0, "R9", "results still pending", q.size(), 0);
    finish_run();
  end

endmodule